// File: doc/BRIEF.md
# JTAG Pin-Sharing and Programming-Status Controller

This block decides when a group of general-purpose port pins is handed to a four-wire JTAG channel. Three sources can claim the pins, and any one of them is enough: a non-volatile dedication bit, a run-time enable bit that the CPU writes, and a select signal from programmable logic. The three sources respond to chip reset in different ways. A chip reset drops a claim that rests only on the run-time bit. It leaves a claim made through the dedication bit or the logic select untouched.

Once the pins are claimed, TMS, TCK, TDI and TDO all start as inputs. The decoded in-system-configuration command strobes then drive a session state machine. An enable command turns TDO into a driven output and hands two extra port bits to the status outputs. The status output follows the flash ready/busy line. The error output is active low and sticky: it is released by a clear command, or by a chip reset that arrives after a disable command.

The session machine has five named states:
- OFF: the pins are not claimed.
- LISTEN: the pins are claimed and TDO is still an input.
- ISC: a programming session is open and the error output is high.
- FAULT: a session is open and the error output is latched low.
- PEND: the session is closed, but the error is held until a reset or a clear.

Transitions, in priority order:
- *release*: any state goes to OFF when no source claims the pins.
- *claim*: OFF goes to LISTEN.
- *open*: LISTEN goes to ISC on an enable.
- *close*: ISC goes to LISTEN on a disable, and this beats an error in the same cycle.
- *trip*: ISC goes to FAULT on a flash error.
- *clear*: FAULT goes to ISC on a clear with no error in the same cycle.
- *close-clean*: FAULT goes to LISTEN on a disable together with a clear and no error.
- *close-dirty*: FAULT goes to PEND on a disable in any other case.
- *flush*: PEND goes to LISTEN on a clear or a chip reset.
- *reopen*: PEND goes to FAULT on an enable.

Top module: `tap_pin_share`

## Requirements
- R1: Port bits 0 (TMS), 1 (TCK), 5 (TDI) and 6 (TDO) are selected for JTAG, giving `port_alt_sel` = 8'h63, whenever the dedication bit, the logic select or the unmasked run-time bit is set. Otherwise `port_alt_sel` is 8'h00. Bits 3 (TSTAT) and 4 (TERR) are added, giving 8'h7B, only while a session state (ISC, FAULT, PEND) is held.
- R2: The run-time bit is bit 0 of the register at address 8'hC7. A write there loads `cpu_wdata[0]`, and a write to any other address has no effect. A read of 8'hC7 returns the bit at position 0 with zeros above it, and a read of any other address returns zero.
- R3: While `chip_reset` is high, the run-time bit is masked at once and is cleared at the next edge. A claim resting only on it ends: `port_alt_sel` reads 0 in that cycle, and the machine is in OFF after the edge.
- R4: While the dedication bit or the logic select holds the claim, `chip_reset` leaves the pins claimed and the session state unchanged, except that it flushes PEND.
- R5: After a claim, `tdo_oe` stays 0 until an enable strobe is seen in LISTEN. An enable strobe while the pins are unclaimed has no effect.
- R6: In a session state, `tstat_out` equals the inverse of `flash_busy`. Outside a session, `tstat_out` is 0 and `terr_n_out` is 1.
- R7: In ISC, `terr_n_out` is 1. A flash error drives it to 0 at the next edge, and it stays 0 with no further stimulus.
- R8: A clear in FAULT returns to ISC, with `terr_n_out` 1 and `tdo_oe` 1. A clear in PEND returns to LISTEN.
- R9: A disable in ISC returns to LISTEN. A disable in FAULT without a clean clear enters PEND, where `tdo_oe` is 0 and `terr_n_out` stays 0 until a chip reset or a clear.
- R10: An enable in PEND reopens the session in FAULT, with `tdo_oe` 1 and `terr_n_out` still 0.
- R11: When every source drops, the machine is in OFF after the next edge, with `tdo_oe` 0, from any state.
- R12: In FAULT, a clear together with a flash error leaves the machine in FAULT. A disable together with a clear and no error goes straight to LISTEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| chip_reset | input | 1 | Functional chip reset, active high, sampled |
| cfg_nv_dedicate | input | 1 | Non-volatile pin dedication bit |
| pt_jtag_sel | input | 1 | Select from programmable logic |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 8 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_raddr | input | 8 | CPU read address |
| cpu_rdata | output | 8 | CPU read data (combinational) |
| isc_enable_stb | input | 1 | Decoded enable command |
| isc_disable_stb | input | 1 | Decoded disable command |
| isc_clear_stb | input | 1 | Decoded clear command |
| flash_busy | input | 1 | Flash busy indication |
| flash_err | input | 1 | Flash erase/program error pulse |
| port_alt_sel | output | 8 | Per-bit JTAG function select for the port |
| tdo_oe | output | 1 | TDO output enable |
| tstat_out | output | 1 | Ready/busy status pin value |
| terr_n_out | output | 1 | Error flag pin value, active low |

## Verification
The hardest state to reach is PEND. The bench must first open a session, then trip an error, then close with a disable that is not paired with a clean clear. Only in that state is the difference between the reset-proof and reset-sensitive claim sources visible on the error pin. The vector table walks this path twice: once under a claim by the run-time bit, where a reset tears the session down to OFF, and once under the dedication bit, where the same reset only flushes PEND to LISTEN. The simultaneous-strobe priorities in FAULT are placed right after a fresh trip.

// File: rtl/tps_pkg.sv
package tps_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_LISTEN = 3'd1,
        ST_ISC    = 3'd2,
        ST_FAULT  = 3'd3,
        ST_PEND   = 3'd4
    } isc_state_e;

    // Port bit positions of each JTAG function (fixed pin map)
    localparam int PIN_TMS   = 0;
    localparam int PIN_TCK   = 1;
    localparam int PIN_TSTAT = 3;
    localparam int PIN_TERR  = 4;
    localparam int PIN_TDI   = 5;
    localparam int PIN_TDO   = 6;

    function automatic logic is_std_pin(input int idx);
        return (idx == PIN_TMS) || (idx == PIN_TCK) ||
               (idx == PIN_TDI) || (idx == PIN_TDO);
    endfunction

    function automatic logic is_ext_pin(input int idx);
        return (idx == PIN_TSTAT) || (idx == PIN_TERR);
    endfunction

endpackage

// File: rtl/tps_en_reg.sv
module tps_en_reg #(
    parameter int              ADDR_W  = 8,
    parameter int              DATA_W  = 8,
    parameter logic [ADDR_W-1:0] EN_ADDR = 8'hC7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_reset,
    input  logic              wr,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              wbit,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              en_masked
);

    logic en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (chip_reset) begin
            en_q <= 1'b0;
        end else if (wr && (waddr == EN_ADDR)) begin
            en_q <= wbit;
        end
    end

    always_comb begin
        rdata = '0;
        if (raddr == EN_ADDR) begin
            rdata[0] = en_q;
        end
    end

    // A chip reset withdraws this source in the same cycle
    assign en_masked = en_q & ~chip_reset;

endmodule

// File: rtl/tps_own_mux.sv
module tps_own_mux
    import tps_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              nv_dedicate,
    input  logic              pt_sel,
    input  logic              reg_en,
    input  logic              ext_on,
    output logic              jtag_on,
    output logic [PORT_W-1:0] alt_sel
);

    assign jtag_on = nv_dedicate | pt_sel | reg_en;

    for (genvar i = 0; i < PORT_W; i++) begin : g_bit
        if (is_std_pin(i)) begin : g_std
            assign alt_sel[i] = jtag_on;
        end else if (is_ext_pin(i)) begin : g_ext
            assign alt_sel[i] = jtag_on & ext_on;
        end else begin : g_gpio
            assign alt_sel[i] = 1'b0;
        end
    end

endmodule

// File: rtl/tps_isc_fsm.sv
module tps_isc_fsm
    import tps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic jtag_on,
    input  logic chip_reset,
    input  logic en_stb,
    input  logic dis_stb,
    input  logic clr_stb,
    input  logic flash_busy,
    input  logic flash_err,
    output logic tdo_oe,
    output logic ext_on,
    output logic tstat,
    output logic terr_n
);

    isc_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (!jtag_on) begin
            st_d = ST_OFF;                               // release
        end else begin
            unique case (st_q)
                ST_OFF:    st_d = ST_LISTEN;             // claim
                ST_LISTEN: if (en_stb) st_d = ST_ISC;    // open
                ST_ISC: begin
                    if (dis_stb)        st_d = ST_LISTEN; // close
                    else if (flash_err) st_d = ST_FAULT;  // trip
                end
                ST_FAULT: begin
                    if (dis_stb)
                        st_d = (clr_stb && !flash_err) ? ST_LISTEN : ST_PEND;
                    else if (clr_stb && !flash_err)
                        st_d = ST_ISC;                    // clear
                end
                ST_PEND: begin
                    if (clr_stb || chip_reset) st_d = ST_LISTEN; // flush
                    else if (en_stb)           st_d = ST_FAULT;  // reopen
                end
                default: st_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        tdo_oe = 1'b0;
        ext_on = 1'b0;
        tstat  = 1'b0;
        terr_n = 1'b1;
        unique case (st_q)
            ST_OFF, ST_LISTEN: ;
            ST_ISC: begin
                tdo_oe = 1'b1;
                ext_on = 1'b1;
                tstat  = ~flash_busy;
            end
            ST_FAULT: begin
                tdo_oe = 1'b1;
                ext_on = 1'b1;
                tstat  = ~flash_busy;
                terr_n = 1'b0;
            end
            ST_PEND: begin
                ext_on = 1'b1;
                tstat  = ~flash_busy;
                terr_n = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tap_pin_share.sv
module tap_pin_share #(
    parameter int                ADDR_W  = 8,
    parameter int                DATA_W  = 8,
    parameter int                PORT_W  = 8,
    parameter logic [ADDR_W-1:0] EN_ADDR = 8'hC7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_reset,
    input  logic              cfg_nv_dedicate,
    input  logic              pt_jtag_sel,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [ADDR_W-1:0] cpu_raddr,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              isc_enable_stb,
    input  logic              isc_disable_stb,
    input  logic              isc_clear_stb,
    input  logic              flash_busy,
    input  logic              flash_err,
    output logic [PORT_W-1:0] port_alt_sel,
    output logic              tdo_oe,
    output logic              tstat_out,
    output logic              terr_n_out
);

    logic reg_en;
    logic jtag_on;
    logic ext_on;

    tps_en_reg #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .EN_ADDR(EN_ADDR)
    ) u_en_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .chip_reset(chip_reset),
        .wr        (cpu_wr),
        .waddr     (cpu_addr),
        .wbit      (cpu_wdata[0]),
        .raddr     (cpu_raddr),
        .rdata     (cpu_rdata),
        .en_masked (reg_en)
    );

    tps_own_mux #(
        .PORT_W(PORT_W)
    ) u_own (
        .nv_dedicate(cfg_nv_dedicate),
        .pt_sel     (pt_jtag_sel),
        .reg_en     (reg_en),
        .ext_on     (ext_on),
        .jtag_on    (jtag_on),
        .alt_sel    (port_alt_sel)
    );

    tps_isc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .jtag_on   (jtag_on),
        .chip_reset(chip_reset),
        .en_stb    (isc_enable_stb),
        .dis_stb   (isc_disable_stb),
        .clr_stb   (isc_clear_stb),
        .flash_busy(flash_busy),
        .flash_err (flash_err),
        .tdo_oe    (tdo_oe),
        .ext_on    (ext_on),
        .tstat     (tstat_out),
        .terr_n    (terr_n_out)
    );

endmodule

// File: rtl/tps_chk.sv
module tps_chk #(
    parameter int DATA_W = 8,
    parameter int PORT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chip_reset,
    input logic              cfg_nv_dedicate,
    input logic              pt_jtag_sel,
    input logic              isc_enable_stb,
    input logic              isc_disable_stb,
    input logic              isc_clear_stb,
    input logic              flash_busy,
    input logic              flash_err,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic [PORT_W-1:0] port_alt_sel,
    input logic              tdo_oe,
    input logic              tstat_out,
    input logic              terr_n_out
);

    // R2
    rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata[DATA_W-1:1] == '0);

    // R3
    reset_drops_reg_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_reset && !cfg_nv_dedicate && !pt_jtag_sel) |-> !port_alt_sel[0]);

    // R4
    reset_keeps_session_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_nv_dedicate && chip_reset && tdo_oe && !isc_disable_stb)
            |=> (tdo_oe || !port_alt_sel[0]));

    // R5
    tdo_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tdo_oe) |-> $past(isc_enable_stb));

    // R6
    tstat_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_alt_sel[3] |-> (tstat_out == !flash_busy));

    // R7
    terr_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(terr_n_out) |-> $past(flash_err));

    // R8
    terr_release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(terr_n_out) |-> ($past(isc_clear_stb) || $past(chip_reset) ||
                               $past(!port_alt_sel[0])));

    // R11
    release_to_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_alt_sel[0] |=> !tdo_oe);

endmodule

bind tap_pin_share tps_chk #(
    .DATA_W(DATA_W),
    .PORT_W(PORT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .chip_reset     (chip_reset),
    .cfg_nv_dedicate(cfg_nv_dedicate),
    .pt_jtag_sel    (pt_jtag_sel),
    .isc_enable_stb (isc_enable_stb),
    .isc_disable_stb(isc_disable_stb),
    .isc_clear_stb  (isc_clear_stb),
    .flash_busy     (flash_busy),
    .flash_err      (flash_err),
    .cpu_rdata      (cpu_rdata),
    .port_alt_sel   (port_alt_sel),
    .tdo_oe         (tdo_oe),
    .tstat_out      (tstat_out),
    .terr_n_out     (terr_n_out)
);

// File: tb/sim_tap_pin_share.sv
module sim_tap_pin_share;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chip_reset = 1'b0;
    logic       cfg_nv_dedicate = 1'b0;
    logic       pt_jtag_sel = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_addr = 8'h00;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_raddr = 8'h00;
    logic [7:0] cpu_rdata;
    logic       isc_enable_stb = 1'b0;
    logic       isc_disable_stb = 1'b0;
    logic       isc_clear_stb = 1'b0;
    logic       flash_busy = 1'b0;
    logic       flash_err = 1'b0;
    logic [7:0] port_alt_sel;
    logic       tdo_oe;
    logic       tstat_out;
    logic       terr_n_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tap_pin_share u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .chip_reset     (chip_reset),
        .cfg_nv_dedicate(cfg_nv_dedicate),
        .pt_jtag_sel    (pt_jtag_sel),
        .cpu_wr         (cpu_wr),
        .cpu_addr       (cpu_addr),
        .cpu_wdata      (cpu_wdata),
        .cpu_raddr      (cpu_raddr),
        .cpu_rdata      (cpu_rdata),
        .isc_enable_stb (isc_enable_stb),
        .isc_disable_stb(isc_disable_stb),
        .isc_clear_stb  (isc_clear_stb),
        .flash_busy     (flash_busy),
        .flash_err      (flash_err),
        .port_alt_sel   (port_alt_sel),
        .tdo_oe         (tdo_oe),
        .tstat_out      (tstat_out),
        .terr_n_out     (terr_n_out)
    );

    // Vector: {in[9:0], alt[7:0], {oe,tstat,terr_n}, req[3:0]}
    // in = {chip_reset, nv, pt, wr@C7, wdata0, enable, disable, clear, busy, err}
    localparam int NV = 32;
    localparam logic [24:0] VEC [NV] = '{
        {10'b0000000000, 8'h00, 3'b001, 4'd1},  // R1 idle, unclaimed
        {10'b0001100000, 8'h63, 3'b001, 4'd1},  // R1 run-time bit set
        {10'b0000000000, 8'h63, 3'b001, 4'd5},  // R5 LISTEN, TDO input
        {10'b0000010000, 8'h7B, 3'b111, 4'd5},  // R5 open
        {10'b0000000010, 8'h7B, 3'b101, 4'd6},  // R6 busy
        {10'b0000000001, 8'h7B, 3'b110, 4'd7},  // R7 trip
        {10'b0000000000, 8'h7B, 3'b110, 4'd7},  // R7 sticky
        {10'b0000000100, 8'h7B, 3'b111, 4'd8},  // R8 clear
        {10'b0000000001, 8'h7B, 3'b110, 4'd7},  // R7 trip again
        {10'b0000000101, 8'h7B, 3'b110, 4'd12}, // R12 clear+err
        {10'b0000001100, 8'h63, 3'b001, 4'd12}, // R12 disable+clear
        {10'b0000010000, 8'h7B, 3'b111, 4'd5},  // R5 reopen
        {10'b0000000001, 8'h7B, 3'b110, 4'd7},  // R7
        {10'b0000001000, 8'h7B, 3'b010, 4'd9},  // R9 dirty close
        {10'b0000000000, 8'h7B, 3'b010, 4'd9},  // R9 held
        {10'b0000010000, 8'h7B, 3'b110, 4'd10}, // R10 reopen to FAULT
        {10'b0000001000, 8'h7B, 3'b010, 4'd9},  // R9
        {10'b0000000100, 8'h63, 3'b001, 4'd8},  // R8 clear in PEND
        {10'b1000000000, 8'h00, 3'b001, 4'd3},  // R3 reset drops reg claim
        {10'b0000000000, 8'h00, 3'b001, 4'd3},  // R3 bit cleared
        {10'b0100000000, 8'h63, 3'b001, 4'd1},  // R1 dedication bit
        {10'b0100010000, 8'h7B, 3'b111, 4'd5},  // R5
        {10'b0100000001, 8'h7B, 3'b110, 4'd7},  // R7
        {10'b1100000000, 8'h7B, 3'b110, 4'd4},  // R4 reset ignored in FAULT
        {10'b0100001000, 8'h7B, 3'b010, 4'd9},  // R9
        {10'b1100000000, 8'h63, 3'b001, 4'd9},  // R9 reset flushes PEND
        {10'b0100000000, 8'h63, 3'b001, 4'd4},  // R4 still claimed
        {10'b0010000000, 8'h63, 3'b001, 4'd1},  // R1 logic select
        {10'b0010010000, 8'h7B, 3'b111, 4'd5},  // R5
        {10'b1010000000, 8'h7B, 3'b111, 4'd4},  // R4 reset ignored in ISC
        {10'b0000000000, 8'h00, 3'b001, 4'd11}, // R11 release
        {10'b0000010000, 8'h00, 3'b001, 4'd5}   // R5 enable ignored
    };

    task automatic drive(input logic [9:0] v);
        chip_reset      = v[9];
        cfg_nv_dedicate = v[8];
        pt_jtag_sel     = v[7];
        cpu_wr          = v[6];
        cpu_addr        = 8'hC7;
        cpu_wdata       = {7'b0, v[5]};
        isc_enable_stb  = v[4];
        isc_disable_stb = v[3];
        isc_clear_stb   = v[2];
        flash_busy      = v[1];
        flash_err       = v[0];
    endtask

    task automatic check(input int req, input string what,
                         input logic [10:0] act, input logic [10:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic outs_chk(input int req, input string what,
                            input logic [7:0] alt, input logic [2:0] o);
        check(req, what, {port_alt_sel, tdo_oe, tstat_out, terr_n_out}, {alt, o});
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        outs_chk(1, "reset state", 8'h00, 3'b001);   // R1 R6
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][24:15]);
            @(posedge clk);
            @(negedge clk);
            outs_chk(int'(VEC[i][3:0]), $sformatf("vector %0d", i),
                     VEC[i][14:7], VEC[i][6:4]);
        end
        drive('0);

        // R2: write to a neighbouring address is ignored
        cpu_wr = 1'b1; cpu_addr = 8'hC6; cpu_wdata = 8'h01;
        @(posedge clk); @(negedge clk);
        cpu_wr = 1'b0; cpu_raddr = 8'hC7; #1;
        check(2, "readback after stray write", {3'b0, cpu_rdata}, 11'h000);
        outs_chk(2, "no claim after stray write", 8'h00, 3'b001);

        // R2: only bit 0 is stored and read back
        cpu_wr = 1'b1; cpu_addr = 8'hC7; cpu_wdata = 8'hFF;
        @(posedge clk); @(negedge clk);
        cpu_wr = 1'b0; #1;
        check(2, "readback of enable register", {3'b0, cpu_rdata}, 11'h001);
        cpu_raddr = 8'hC6; #1;
        check(2, "read of other address", {3'b0, cpu_rdata}, 11'h000);
        outs_chk(1, "claim by run-time bit", 8'h63, 3'b001);

        // R11: CPU clears the bit during an open session
        @(negedge clk);
        isc_enable_stb = 1'b1;
        @(negedge clk);
        isc_enable_stb = 1'b0;
        outs_chk(5, "session open", 8'h7B, 3'b111);
        cpu_wr = 1'b1; cpu_wdata = 8'h00;
        @(posedge clk); @(negedge clk);
        cpu_wr = 1'b0;
        outs_chk(11, "pins released after CPU clear", 8'h00, 3'b111);
        @(negedge clk);
        outs_chk(11, "session torn down", 8'h00, 3'b001);

        // R3: PEND under run-time claim, reset goes to OFF
        cpu_wr = 1'b1; cpu_wdata = 8'h01;
        @(negedge clk);
        cpu_wr = 1'b0;
        @(negedge clk);
        isc_enable_stb = 1'b1; @(negedge clk); isc_enable_stb = 1'b0;
        flash_err = 1'b1;      @(negedge clk); flash_err = 1'b0;
        isc_disable_stb = 1'b1; @(negedge clk); isc_disable_stb = 1'b0;
        outs_chk(9, "PEND under run-time claim", 8'h7B, 3'b010);
        chip_reset = 1'b1;
        @(negedge clk);
        chip_reset = 1'b0;
        outs_chk(3, "reset ends run-time claim from PEND", 8'h00, 3'b001);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule